// File: doc/BRIEF.md
# SD Host Command Issue Engine

This block sends one SD command and collects the card's reply on the bidirectional CMD line. A host write presents a 32-bit command word and a 32-bit argument together. The engine then builds the 48-bit command frame, appends its CRC7 and shifts the frame out one bit per SD clock period. After that it waits for the card's response, which may be absent, 48 bits long, or 136 bits long.

The response is checked against the options in the command word: CRC check, index check and end bit. The card-supplied payload is placed in four 32-bit response words. A busy-type response keeps the engine occupied until the card releases DAT0. A command-inhibit output stays high for the whole operation. At the end, exactly one sticky outcome flag is raised: command done, or one of the error flags. The flags are cleared by the next accepted command.

`sd_stb_i` marks each SD clock period. The engine drives the CMD line and samples it on strobe cycles, so the clock divider stays outside this block.

Top module: `sdcmd_engine`

## Requirements
- R1: The transmitted frame is sent MSB first, one bit per strobe. Its 48 bits are, in order: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, zero seed) over the preceding 40 bits, and a 1 end bit. `cmd_oe_o` is high while the frame is driven. When idle, `cmd_o` rests at 1.
- R2: `cmd_inhibit_o` rises on the cycle after an accepted command write. It stays high until the command has completed or failed.
- R3: In the command word, bits 29:24 are the index and bits 17:16 the response type (0 none, 1 long 136-bit, 2 short 48-bit, 3 short 48-bit with busy). Bit 19 enables the response CRC check and bit 20 enables the response index check.
- R4: With response type 0, `int_done_o` is set and inhibit drops at the strobe that drives the end bit. The response words are left unchanged.
- R5: For a short response, the 32 bits that follow the index field land in `resp0_o`.
- R6: For a long response, the 120 bits that lie between the 8-bit header and the CRC7/end byte are stored right-aligned across `resp3_o..resp0_o`. Bits 31:24 of `resp3_o` read 0.
- R7: When the CRC check is enabled and the received CRC7 differs from one computed over the response, `int_crc_o` is set. For a short response that computation covers the first 40 bits; for a long one it covers the 120 payload bits. When the check is disabled, a bad CRC has no effect.
- R8: When the index check is enabled on a short response and the response index differs from the command index, `int_index_o` is set.
- R9: A response whose last bit is 0 sets `int_end_o`.
- R10: If no start bit appears within TIMEOUT_CYC strobes after the end bit is sent, `int_timeout_o` is set and inhibit drops on the TIMEOUT_CYC-th waiting strobe.
- R11: For response type 3 with no error, inhibit stays high and `int_done_o` stays low until DAT0 is sampled high. Then done is raised.
- R12: A command write made while inhibit is high is ignored: no second frame is sent and the running command completes normally.
- R13: A pulse on `srst_cmd_i` aborts any operation. On the next cycle inhibit is low, the line is released with `cmd_o` at 1, and all flags are cleared.
- R14: The done flag and the error flags are never set together. All of them clear on the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sd_stb_i | input | 1 | One-cycle strobe per SD clock period |
| cmd_wr_i | input | 1 | Command write pulse |
| cmd_word_i | input | 32 | Command word (index, response type, check enables) |
| cmd_arg_i | input | 32 | Command argument |
| srst_cmd_i | input | 1 | Command-circuit soft reset pulse |
| cmd_i | input | 1 | CMD line as seen from the card |
| dat0_i | input | 1 | DAT0 line, low while the card is busy |
| cmd_o | output | 1 | CMD line drive value |
| cmd_oe_o | output | 1 | CMD line drive enable |
| cmd_inhibit_o | output | 1 | Engine busy |
| int_done_o | output | 1 | Command done flag |
| int_timeout_o | output | 1 | Response timeout flag |
| int_crc_o | output | 1 | Response CRC error flag |
| int_end_o | output | 1 | Response end-bit error flag |
| int_index_o | output | 1 | Response index mismatch flag |
| resp0_o | output | 32 | Response word 0 |
| resp1_o | output | 32 | Response word 1 |
| resp2_o | output | 32 | Response word 2 |
| resp3_o | output | 32 | Response word 3 |

## Verification
The hardest states to reach are the ones that only exist while the engine is waiting on the card. These are a second command write that lands after the frame has gone out but before the reply arrives, and a busy period after a correct busy-type reply. The bench's card model pauses at these points. It pulses the write with a different argument in the middle of the wait window, and it holds DAT0 low for a fixed stretch after the end bit so that inhibit and done can be probed mid-busy. The timeout is timed exactly by counting strobes from the release of the line to the fall of inhibit.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [1:0] {RSP_NONE = 2'd0, RSP_LONG = 2'd1, RSP_SHORT = 2'd2, RSP_BUSY = 2'd3} rsp_e;
  typedef enum logic [2:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX, ST_BUSY} st_e;

  localparam int FRAME_W = 48;
  localparam int LONG_W  = 136;

  function automatic logic [6:0] crc7_step(logic [6:0] c, logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_40(logic [39:0] v);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  import sdcmd_pkg::*;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_o <= '0;
    else if (clr_i) crc_o <= '0;
    else if (en_i)  crc_o <= crc7_step(crc_o, bit_i);
  end
endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] frame_i,
  input  logic         shift_i,
  output logic         bit_o,
  output logic         last_o
);
  localparam int CW = $clog2(W);
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= frame_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[W-2:0], 1'b1};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_o  = sh_q[W-1];
  assign last_o = (cnt_q == CW'(W - 1));
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sd_stb_i,
  input  logic        cmd_wr_i,
  input  logic [31:0] cmd_word_i,
  input  logic [31:0] cmd_arg_i,
  input  logic        srst_cmd_i,
  input  logic        cmd_i,
  input  logic        dat0_i,
  output logic        cmd_o,
  output logic        cmd_oe_o,
  output logic        cmd_inhibit_o,
  output logic        int_done_o,
  output logic        int_timeout_o,
  output logic        int_crc_o,
  output logic        int_end_o,
  output logic        int_index_o,
  output logic [31:0] resp0_o,
  output logic [31:0] resp1_o,
  output logic [31:0] resp2_o,
  output logic [31:0] resp3_o
);
  import sdcmd_pkg::*;

  localparam int TO_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int RC_W = $clog2(LONG_W + 1);

  st_e              state_q;
  rsp_e             rtype_q;
  logic             crc_chk_q, idx_chk_q;
  logic [5:0]       idx_q;
  logic [LONG_W-1:0] rx_q;
  logic [LONG_W-1:0] rx_next;
  logic [RC_W-1:0]  rcnt_q;
  logic [TO_W-1:0]  tcnt_q;
  logic [6:0]       crc_rx;
  logic             tx_bit, tx_last;

  wire accept   = cmd_wr_i && (state_q == ST_IDLE) && !srst_cmd_i;
  wire is_long  = (rtype_q == RSP_LONG);
  wire rx_last  = (rcnt_q == (is_long ? RC_W'(LONG_W - 1) : RC_W'(FRAME_W - 1)));
  wire in_crc   = is_long ? (rcnt_q >= RC_W'(8) && rcnt_q < RC_W'(LONG_W - 8))
                          : (rcnt_q < RC_W'(FRAME_W - 8));
  wire crc_en   = sd_stb_i && (state_q == ST_RX) && in_crc;

  logic [39:0]        tx_head;
  logic [FRAME_W-1:0] tx_frame;
  assign tx_head  = {2'b01, cmd_word_i[29:24], cmd_arg_i};
  assign tx_frame = {tx_head, crc7_40(tx_head), 1'b1};
  assign rx_next  = {rx_q[LONG_W-2:0], cmd_i};

  wire crc_bad = crc_chk_q && (rx_next[7:1] != crc_rx);
  wire idx_bad = idx_chk_q && !is_long && (rx_next[45:40] != idx_q);
  wire end_bad = !rx_next[0];

  sdcmd_tx #(.W(FRAME_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .frame_i (tx_frame),
    .shift_i (sd_stb_i && state_q == ST_TX),
    .bit_o   (tx_bit),
    .last_o  (tx_last)
  );

  sdcmd_crc7 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_WAIT),
    .en_i   (crc_en),
    .bit_i  (cmd_i),
    .crc_o  (crc_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rtype_q   <= RSP_NONE;
      crc_chk_q <= 1'b0;
      idx_chk_q <= 1'b0;
      idx_q     <= '0;
      rx_q      <= '0;
      rcnt_q    <= '0;
      tcnt_q    <= '0;
      cmd_o     <= 1'b1;
      cmd_oe_o  <= 1'b0;
      {int_done_o, int_timeout_o, int_crc_o, int_end_o, int_index_o} <= '0;
      {resp3_o, resp2_o, resp1_o, resp0_o} <= '0;
    end else if (srst_cmd_i) begin
      state_q  <= ST_IDLE;
      cmd_o    <= 1'b1;
      cmd_oe_o <= 1'b0;
      {int_done_o, int_timeout_o, int_crc_o, int_end_o, int_index_o} <= '0;
    end else begin
      if (sd_stb_i) begin
        cmd_oe_o <= (state_q == ST_TX);
        cmd_o    <= (state_q == ST_TX) ? tx_bit : 1'b1;
      end
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_TX;
          rtype_q   <= rsp_e'(cmd_word_i[17:16]);
          crc_chk_q <= cmd_word_i[19];
          idx_chk_q <= cmd_word_i[20];
          idx_q     <= cmd_word_i[29:24];
          {int_done_o, int_timeout_o, int_crc_o, int_end_o, int_index_o} <= '0;
        end
        ST_TX: if (sd_stb_i && tx_last) begin
          tcnt_q <= '0;
          if (rtype_q == RSP_NONE) begin
            int_done_o <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (sd_stb_i) begin
          if (!cmd_i) begin
            state_q <= ST_RX;
            rcnt_q  <= RC_W'(1);
            rx_q    <= rx_next;
          end else if (tcnt_q == TO_W'(TIMEOUT_CYC - 1)) begin
            int_timeout_o <= 1'b1;
            state_q       <= ST_IDLE;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_RX: if (sd_stb_i) begin
          rx_q   <= rx_next;
          rcnt_q <= rcnt_q + 1'b1;
          if (rx_last) begin
            if (is_long) {resp3_o, resp2_o, resp1_o, resp0_o} <= {8'h00, rx_next[127:8]};
            else         resp0_o <= rx_next[39:8];
            int_crc_o   <= crc_bad;
            int_index_o <= idx_bad;
            int_end_o   <= end_bad;
            if (crc_bad || idx_bad || end_bad) state_q <= ST_IDLE;
            else if (rtype_q == RSP_BUSY)      state_q <= ST_BUSY;
            else begin
              int_done_o <= 1'b1;
              state_q    <= ST_IDLE;
            end
          end
        end
        ST_BUSY: if (sd_stb_i && dat0_i) begin
          int_done_o <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_inhibit_o = (state_q != ST_IDLE);

  AST_ACCEPT_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> cmd_inhibit_o); // R2
  AST_SRST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_cmd_i |=> (!cmd_inhibit_o && !cmd_oe_o && cmd_o)); // R13
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_done_o |-> !(int_timeout_o || int_crc_o || int_end_o || int_index_o)); // R14
  AST_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_oe_o) |-> !cmd_o); // R1
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && !dat0_i && !srst_cmd_i) |=> (cmd_inhibit_o && !int_done_o)); // R11
  AST_IGNORE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_inhibit_o && !srst_cmd_i) |=> $stable(idx_q)); // R12
endmodule

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0, srst = 1'b0, card_cmd = 1'b1, dat0 = 1'b1;
  logic [31:0] word = '0, arg = '0;
  logic cmd_o, cmd_oe, inhibit, f_done, f_to, f_crc, f_end, f_idx;
  logic [31:0] r0, r1, r2, r3;

  always #2 clk = ~clk;

  sdcmd_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sd_stb_i(1'b1), .cmd_wr_i(cmd_wr),
    .cmd_word_i(word), .cmd_arg_i(arg), .srst_cmd_i(srst), .cmd_i(card_cmd),
    .dat0_i(dat0), .cmd_o(cmd_o), .cmd_oe_o(cmd_oe), .cmd_inhibit_o(inhibit),
    .int_done_o(f_done), .int_timeout_o(f_to), .int_crc_o(f_crc),
    .int_end_o(f_end), .int_index_o(f_idx),
    .resp0_o(r0), .resp1_o(r1), .resp2_o(r2), .resp3_o(r3)
  );

  typedef struct {
    logic [47:0]  frame;
    logic [4:0]   flags;
    logic         chk_resp;
    logic [127:0] resp;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0, frames = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [6:0] tb_crc(logic [135:0] v, int n);
    logic [6:0] c = '0;
    logic fb;
    for (int i = n - 1; i >= 0; i--) begin
      fb = v[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [31:0] mkw(logic [5:0] idx, logic [1:0] rt, bit crc, bit ix);
    return (32'(idx) << 24) | (32'(ix) << 20) | (32'(crc) << 19) | (32'(rt) << 16);
  endfunction

  function automatic logic [47:0] mkframe(logic [5:0] idx, logic [31:0] a);
    logic [39:0] h = {2'b01, idx, a};
    return {h, tb_crc({96'h0, h}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] mk48(logic [5:0] idx, logic [31:0] st, bit bad_crc, bit endb);
    logic [39:0] h = {2'b00, idx, st};
    logic [6:0]  c = tb_crc({96'h0, h}, 40) ^ (bad_crc ? 7'h11 : 7'h00);
    return {88'h0, h, c, endb};
  endfunction

  function automatic logic [135:0] mk136(logic [119:0] p);
    return {8'h3f, p, tb_crc({16'h0, p}, 120), 1'b1};
  endfunction

  // Monitor: collects driven frames and scores each completion
  initial begin
    logic [47:0] sh;
    int nb;
    bit prev_inh, prev_oe;
    exp_t e;
    sh = '0; nb = 0; prev_inh = 0; prev_oe = 0;
    forever begin
      @(negedge clk);
      if (cmd_oe && !prev_oe) begin nb = 0; frames++; end
      if (cmd_oe) begin sh = {sh[46:0], cmd_o}; nb++; end
      if (prev_inh && !inhibit && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(nb == 48 && sh == e.frame, {e.tag, " R1 frame"}, 128'(sh), 128'(e.frame));
        check({f_done, f_to, f_crc, f_end, f_idx} == e.flags, {e.tag, " flags"},
              128'({f_done, f_to, f_crc, f_end, f_idx}), 128'(e.flags));
        if (e.chk_resp)
          check({r3, r2, r1, r0} == e.resp, {e.tag, " resp"}, {r3, r2, r1, r0}, e.resp);
      end
      prev_inh = inhibit;
      prev_oe  = cmd_oe;
    end
  end

  task automatic wr(logic [31:0] w, logic [31:0] a);
    word = w; arg = a; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_tx;
    do @(negedge clk); while (!cmd_oe);
    do @(negedge clk); while (cmd_oe);
  endtask

  task automatic send_rsp(logic [135:0] bits, int n, bit busy);
    repeat (2) @(negedge clk);
    if (busy) dat0 = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      card_cmd = bits[i];
      @(negedge clk);
    end
    card_cmd = 1'b1;
  endtask

  task automatic wait_idle;
    while (inhibit) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(logic [31:0] w, logic [31:0] a, logic [135:0] rsp, int n,
                     logic [4:0] fl, bit chk, logic [127:0] rv, string tag);
    exp_t e;
    e.frame = mkframe(w[29:24], a); e.flags = fl; e.chk_resp = chk; e.resp = rv; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    wr(w, a);
    wait_tx();
    if (n > 0) send_rsp(rsp, n, 1'b0);
    wait_idle();
  endtask

  initial begin
    logic [119:0] pl;
    logic [127:0] rv;
    int k, fr0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!inhibit && cmd_o && !cmd_oe, "R2 reset idle", 128'({inhibit, cmd_o, cmd_oe}), 128'(3'b010));
    check({f_done, f_to, f_crc, f_end, f_idx} == 0 && {r3, r2, r1, r0} == 0, "R14 reset flags",
          128'({f_done, f_to, f_crc, f_end, f_idx}), 128'h0);

    // R4: no response, resp words untouched (still zero)
    run(mkw(6'd0, 2'd0, 0, 0), 32'h0, '0, 0, 5'b10000, 1, 128'h0, "R4 none");
    // R3 R5: short response, both checks on
    run(mkw(6'd17, 2'd2, 1, 1), 32'h1234_5678, mk48(6'd17, 32'hCAFE_0900, 0, 1), 48,
        5'b10000, 1, 128'(32'hCAFE_0900), "R5 short");
    // R7: bad CRC flagged when enabled
    run(mkw(6'd13, 2'd2, 1, 0), 32'hA5A5_0001, mk48(6'd13, 32'h0000_0F0F, 1, 1), 48,
        5'b00100, 0, 0, "R7 crc on");
    // R7: bad CRC ignored when disabled
    run(mkw(6'd13, 2'd2, 0, 0), 32'hA5A5_0002, mk48(6'd13, 32'h0000_1111, 1, 1), 48,
        5'b10000, 1, 128'(32'h0000_1111), "R7 crc off");
    // R8: index mismatch
    run(mkw(6'd8, 2'd2, 1, 1), 32'h0000_01AA, mk48(6'd9, 32'h0000_01AA, 0, 1), 48,
        5'b00001, 0, 0, "R8 idx on");
    run(mkw(6'd8, 2'd2, 1, 0), 32'h0000_01AB, mk48(6'd9, 32'h0000_01AB, 0, 1), 48,
        5'b10000, 0, 0, "R8 idx off");
    // R9: end bit zero
    run(mkw(6'd55, 2'd2, 1, 1), 32'h0, mk48(6'd55, 32'h0000_0120, 0, 0), 48,
        5'b00010, 0, 0, "R9 end");
    // R6: long response
    pl = {40'hFEDCBA9876, 40'h0123456789, 40'h55AA33CC0F};
    rv = {8'h00, pl};
    run(mkw(6'd2, 2'd1, 1, 0), 32'h0, mk136(pl), 136, 5'b10000, 1, rv, "R6 long");

    // R10: timeout, exact strobe count
    begin
      exp_t e;
      e.frame = mkframe(6'd5, 32'h00FF_8000); e.flags = 5'b01000; e.chk_resp = 0; e.resp = 0;
      e.tag = "R10 timeout";
      exp_q.push_back(e);
      @(negedge clk);
      wr(mkw(6'd5, 2'd2, 0, 0), 32'h00FF_8000);
      wait_tx();
      k = 0;
      while (inhibit && k < 200) begin @(negedge clk); k++; end
      check(k == 63, "R10 timeout window", 128'(k), 128'(63));
      @(negedge clk);
    end

    // R11: busy response
    begin
      exp_t e;
      e.frame = mkframe(6'd7, 32'h0001_0000); e.flags = 5'b10000; e.chk_resp = 1;
      e.resp = {r3, r2, r1, 32'h0000_0700}; e.tag = "R11 busy";
      exp_q.push_back(e);
      @(negedge clk);
      wr(mkw(6'd7, 2'd3, 1, 1), 32'h0001_0000);
      wait_tx();
      send_rsp(mk48(6'd7, 32'h0000_0700, 0, 1), 48, 1'b1);
      repeat (10) @(negedge clk);
      check(inhibit && !f_done, "R11 held while busy", 128'({inhibit, f_done}), 128'(2'b10));
      dat0 = 1'b1;
      wait_idle();
    end

    // R12: write during wait is ignored
    begin
      exp_t e;
      e.frame = mkframe(6'd16, 32'h0000_0200); e.flags = 5'b10000; e.chk_resp = 1;
      e.resp = {r3, r2, r1, 32'h0000_0900}; e.tag = "R12 ignore";
      exp_q.push_back(e);
      @(negedge clk);
      wr(mkw(6'd16, 2'd2, 1, 1), 32'h0000_0200);
      wait_tx();
      fr0 = frames;
      wr(mkw(6'd24, 2'd0, 0, 0), 32'hDEAD_BEEF);
      send_rsp(mk48(6'd16, 32'h0000_0900, 0, 1), 48, 1'b0);
      wait_idle();
      repeat (60) @(negedge clk);
      check(frames == fr0 && !inhibit, "R12 no second frame", 128'(frames), 128'(fr0));
    end

    // R13: soft reset mid-frame
    @(negedge clk);
    wr(mkw(6'd3, 2'd2, 1, 1), 32'h0);
    repeat (10) @(negedge clk);
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    check(!inhibit && !cmd_oe && cmd_o && !f_done, "R13 abort",
          128'({inhibit, cmd_oe, cmd_o, f_done}), 128'(4'b0010));
    // R14: after abort, a new command runs and flags are cleared/raised again
    run(mkw(6'd0, 2'd0, 0, 0), 32'h0000_0001, '0, 0, 5'b10000, 0, 0, "R14 after abort");

    check(exp_q.size() == 0, "R2 all completions seen", 128'(exp_q.size()), 128'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule